// File: doc/BRIEF.md
# Coherence Transition Checker

This block sits beside a cache controller and checks every coherence state change that the controller reports as it happens at runtime. It keeps a private shadow copy of the architected per-line coherence state (Invalid, Shared, Modified) in its own small tag array. For each reported transition it looks up the line's stored state. It recomputes the expected final state and bus action with a plain three-state model. It then compares the controller's report against that expectation on three fields: initial state, final state and action.

A transition that agrees with the model updates the shadow tag. If the change is one that other nodes must learn about (a fill from Invalid, an upgrade, or a loss of a Modified copy), a record of line address and new state is queued for broadcast on a validation bus. A disagreement raises a one-cycle error pulse with a diagnosis code and the line address. The shadow state is left untouched. A watchdog covers the omission case: it is armed when the controller issues a request, and it raises a timeout if the matching local completion does not arrive within a programmable number of cycles.

Top module: `coh_txn_checker`

## Requirements
- R1: After reset every shadow line holds Invalid, `txn_ready` is 1, `vb_valid`, `err_valid` and `wd_timeout` are 0 and `err_code` is 0.
- R2: State encoding is Invalid=0, Shared=1, Modified=2. A reported initial state that differs from the shadow state of the line gives diagnosis code 1.
- R3: If the initial state matches but the reported final state differs from the model's next state, the diagnosis code is 2.
- R4: If both states match but the reported action differs from the model's action, the code is 3. Code 0 means no error, and code 1 takes precedence over 2, which takes precedence over 3.
- R5: The model uses kind encodings load=0, store=1, snoop-read=2, snoop-read-exclusive=3, evict=4, and action encodings none=0, bus-read=1, bus-read-exclusive=2, writeback=3. From I: load gives S with bus-read, store gives M with bus-read-exclusive, and the rest give I with none. From S: store gives M with bus-read-exclusive, snoop-read-exclusive and evict give I with none, and the rest give S with none. From M: load and store give M with none, snoop-read gives S with writeback, and snoop-read-exclusive and evict give I with writeback. Kinds 5 to 7 leave the state unchanged with action none.
- R6: An accepted transition with code 0 writes the model's next state into the shadow tag. One with a nonzero code leaves the tag unchanged and queues nothing.
- R7: A record {address, new state} is queued only for the error-free changes I to S, I to M, S to M and M to I. M to S and S to I are not queued.
- R8: Queued records leave in order on `vb_addr`/`vb_state` while `vb_valid` is high, and each one stays until a cycle with `vb_ready` high. The buffer holds 4 records. While it is full, `txn_ready` is 0 and no transition is accepted.
- R9: `req_issue` arms the watchdog for `req_addr` and clears `wd_timeout`. An accepted load or store to the armed address disarms it. If the watchdog is still armed `wd_limit` cycles after the issue, `wd_timeout` rises and stays high until the next `req_issue`.
- R10: `err_valid`, `err_code` and `err_addr` are registered and change in the cycle after the accepting edge. `err_valid` is high for that single cycle, and `err_code` holds the code of the most recently accepted transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txn_valid | input | 1 | Reported transition present |
| txn_ready | output | 1 | Checker can accept a transition |
| txn_addr | input | ADDR_W | Line index of the transition |
| txn_kind | input | 3 | Request or snoop kind that caused it |
| txn_init | input | 2 | Reported initial state |
| txn_final | input | 2 | Reported final state |
| txn_act | input | 2 | Reported bus action |
| err_valid | output | 1 | One-cycle mismatch pulse |
| err_code | output | 2 | Diagnosis of last accepted transition |
| err_addr | output | ADDR_W | Line of last accepted transition |
| vb_valid | output | 1 | Broadcast record available |
| vb_ready | input | 1 | Validation bus takes the record |
| vb_addr | output | ADDR_W | Broadcast line index |
| vb_state | output | 2 | Broadcast new state |
| req_issue | input | 1 | Controller issued a local request |
| req_addr | input | ADDR_W | Line of the issued request |
| wd_limit | input | WD_W | Watchdog cycle limit (at least 1) |
| wd_timeout | output | 1 | Sticky omission flag |

## Verification
On every cycle, the assertions check that the buffer never takes a record while full, that a stalled broadcast record holds still, and that every queued record really changes a line's state. They also check that an error pulse carries a nonzero code and follows an accepted transition, and that a timeout rises only while the watchdog is armed. The bench's scenarios are needed to show the rest: the state table itself, the precedence of the three diagnosis codes, that a rejected transition leaves the tag alone, and which transitions are broadcast. The scenarios also cover the back-pressure point when four records wait, and the exact cycle on which the watchdog fires or is cancelled.

// File: rtl/coh_chk_pkg.sv
package coh_chk_pkg;
  localparam logic [1:0] CS_I = 2'd0;
  localparam logic [1:0] CS_S = 2'd1;
  localparam logic [1:0] CS_M = 2'd2;

  localparam logic [2:0] EV_LOAD    = 3'd0;
  localparam logic [2:0] EV_STORE   = 3'd1;
  localparam logic [2:0] EV_SNP_RD  = 3'd2;
  localparam logic [2:0] EV_SNP_RDX = 3'd3;
  localparam logic [2:0] EV_EVICT   = 3'd4;

  localparam logic [1:0] ACT_NONE  = 2'd0;
  localparam logic [1:0] ACT_RD    = 2'd1;
  localparam logic [1:0] ACT_RDX   = 2'd2;
  localparam logic [1:0] ACT_WB    = 2'd3;

  localparam logic [1:0] DIAG_OK    = 2'd0;
  localparam logic [1:0] DIAG_INIT  = 2'd1;
  localparam logic [1:0] DIAG_NEXT  = 2'd2;
  localparam logic [1:0] DIAG_ACT   = 2'd3;
endpackage

// File: rtl/coh_msi_model.sv
module coh_msi_model
  import coh_chk_pkg::*;
(
  input  logic [1:0] cur_st,
  input  logic [2:0] kind,
  output logic [1:0] nxt_st,
  output logic [1:0] act
);
  // Reference three-state table (R5)
  always_comb begin
    nxt_st = cur_st;
    act    = ACT_NONE;
    unique case (cur_st)
      CS_I: begin
        if (kind == EV_LOAD) begin
          nxt_st = CS_S; act = ACT_RD;
        end else if (kind == EV_STORE) begin
          nxt_st = CS_M; act = ACT_RDX;
        end
      end
      CS_S: begin
        if (kind == EV_STORE) begin
          nxt_st = CS_M; act = ACT_RDX;
        end else if (kind == EV_SNP_RDX || kind == EV_EVICT) begin
          nxt_st = CS_I;
        end
      end
      CS_M: begin
        if (kind == EV_SNP_RD) begin
          nxt_st = CS_S; act = ACT_WB;
        end else if (kind == EV_SNP_RDX || kind == EV_EVICT) begin
          nxt_st = CS_I; act = ACT_WB;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/coh_assert_fifo.sv
module coh_assert_fifo #(
  parameter int W     = 6,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  output logic         full,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] dout
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pop;

  assign full      = (cnt_q == CNT_W'(DEPTH));
  assign out_valid = (cnt_q != '0);
  assign pop       = out_valid && out_ready;
  assign dout      = mem[rd_q];

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (push) wr_d = (wr_q == LAST) ? '0 : wr_q + 1'b1;
    if (pop)  rd_d = (rd_q == LAST) ? '0 : rd_q + 1'b1;
    if (push && !pop)      cnt_d = cnt_q + 1'b1;
    else if (pop && !push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= din;
  end

  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && full));
  a_r8_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(dout)));
endmodule

// File: rtl/coh_watchdog.sv
module coh_watchdog #(
  parameter int AW = 4,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic [AW-1:0] arm_addr,
  input  logic          done,
  input  logic [AW-1:0] done_addr,
  input  logic [CW-1:0] limit,
  output logic          timeout
);
  logic          armed_q, armed_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          to_q, to_d;
  logic          hit;

  assign hit     = done && (done_addr == addr_q);
  assign timeout = to_q;

  always_comb begin
    armed_d = armed_q;
    addr_d  = addr_q;
    cnt_d   = cnt_q;
    to_d    = to_q;
    if (arm) begin
      armed_d = 1'b1;
      addr_d  = arm_addr;
      cnt_d   = '0;
      to_d    = 1'b0;
    end else if (armed_q && hit) begin
      armed_d = 1'b0;
    end else if (armed_q) begin
      if (cnt_q == limit - CW'(1)) begin
        to_d    = 1'b1;
        armed_d = 1'b0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      addr_q  <= '0;
      cnt_q   <= '0;
      to_q    <= 1'b0;
    end else begin
      armed_q <= armed_d;
      addr_q  <= addr_d;
      cnt_q   <= cnt_d;
      to_q    <= to_d;
    end
  end

  a_r9_fire_only_armed: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout) |-> $past(armed_q));
endmodule

// File: rtl/coh_txn_checker.sv
module coh_txn_checker
  import coh_chk_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int WD_W   = 8,
  parameter int QDEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              txn_valid,
  output logic              txn_ready,
  input  logic [ADDR_W-1:0] txn_addr,
  input  logic [2:0]        txn_kind,
  input  logic [1:0]        txn_init,
  input  logic [1:0]        txn_final,
  input  logic [1:0]        txn_act,
  output logic              err_valid,
  output logic [1:0]        err_code,
  output logic [ADDR_W-1:0] err_addr,
  output logic              vb_valid,
  input  logic              vb_ready,
  output logic [ADDR_W-1:0] vb_addr,
  output logic [1:0]        vb_state,
  input  logic              req_issue,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WD_W-1:0]   wd_limit,
  output logic              wd_timeout
);
  localparam int LINES = 1 << ADDR_W;
  localparam int REC_W = ADDR_W + 2;

  logic [1:0]        tags [LINES];
  logic [1:0]        stored, mdl_nxt, mdl_act, diag;
  logic              acc, bcast, push, q_full, tag_we;
  logic [REC_W-1:0]  q_out;
  logic              ev_q, ev_d;
  logic [1:0]        code_q, code_d;
  logic [ADDR_W-1:0] ea_q, ea_d;

  assign stored = tags[txn_addr];

  coh_msi_model u_model (
    .cur_st (stored),
    .kind   (txn_kind),
    .nxt_st (mdl_nxt),
    .act    (mdl_act)
  );

  assign txn_ready = !q_full;
  assign acc       = txn_valid && txn_ready;

  // Diagnosis with precedence initial > next > action (R2, R3, R4)
  always_comb begin
    if (txn_init != stored)       diag = DIAG_INIT;
    else if (txn_final != mdl_nxt) diag = DIAG_NEXT;
    else if (txn_act != mdl_act)   diag = DIAG_ACT;
    else                           diag = DIAG_OK;
  end

  // Broadcast subset (R7)
  always_comb begin
    bcast = 1'b0;
    if (stored == CS_I && (mdl_nxt == CS_S || mdl_nxt == CS_M)) bcast = 1'b1;
    if (stored == CS_S && mdl_nxt == CS_M)                     bcast = 1'b1;
    if (stored == CS_M && mdl_nxt == CS_I)                     bcast = 1'b1;
  end

  assign tag_we = acc && (diag == DIAG_OK);
  assign push   = tag_we && bcast;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) tags[i] <= CS_I;
    end else if (tag_we) begin
      tags[txn_addr] <= mdl_nxt;
    end
  end

  always_comb begin
    ev_d   = acc && (diag != DIAG_OK);
    code_d = acc ? diag : code_q;
    ea_d   = acc ? txn_addr : ea_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_q   <= 1'b0;
      code_q <= DIAG_OK;
      ea_q   <= '0;
    end else begin
      ev_q   <= ev_d;
      code_q <= code_d;
      ea_q   <= ea_d;
    end
  end

  assign err_valid = ev_q;
  assign err_code  = code_q;
  assign err_addr  = ea_q;

  coh_assert_fifo #(.W(REC_W), .DEPTH(QDEPTH)) u_sendq (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .din       ({txn_addr, mdl_nxt}),
    .full      (q_full),
    .out_valid (vb_valid),
    .out_ready (vb_ready),
    .dout      (q_out)
  );

  assign vb_addr  = q_out[REC_W-1:2];
  assign vb_state = q_out[1:0];

  coh_watchdog #(.AW(ADDR_W), .CW(WD_W)) u_wd (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm       (req_issue),
    .arm_addr  (req_addr),
    .done      (acc && (txn_kind == EV_LOAD || txn_kind == EV_STORE)),
    .done_addr (txn_addr),
    .limit     (wd_limit),
    .timeout   (wd_timeout)
  );

  a_r4_code_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> (err_code != DIAG_OK));
  a_r10_err_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> $past(txn_valid && txn_ready));
  a_r7_bcast_changes_state: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (mdl_nxt != stored));
endmodule

// File: tb/tb_coh_txn_checker.sv
module tb_coh_txn_checker;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int CW = 8;

  logic          clk, rst_n;
  logic          txn_valid, txn_ready;
  logic [AW-1:0] txn_addr;
  logic [2:0]    txn_kind;
  logic [1:0]    txn_init, txn_final, txn_act;
  logic          err_valid;
  logic [1:0]    err_code;
  logic [AW-1:0] err_addr;
  logic          vb_valid, vb_ready;
  logic [AW-1:0] vb_addr;
  logic [1:0]    vb_state;
  logic          req_issue;
  logic [AW-1:0] req_addr;
  logic [CW-1:0] wd_limit;
  logic          wd_timeout;

  coh_txn_checker #(.ADDR_W(AW), .WD_W(CW), .QDEPTH(4)) dut (.*);

  int n_run, n_fail;
  string tag;

  // reference model state (values after the latest edge)
  int        m_tag [16];
  logic [5:0] m_q [$];
  bit        m_ev;
  int        m_code, m_eaddr;
  bit        m_armed, m_to;
  int        m_cnt, m_waddr;
  bit        m_acc;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 20000);
    n_fail++;
    $display("FAIL watchdog expired: actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  task automatic chk(string name, string t, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d t=%0t", t, name, act, exp, $time);
    end
  endtask

  function automatic void ref_tbl(int cur, int k, output int nx, output int ac);
    nx = cur; ac = 0;
    case (cur)
      0: if (k == 0) begin nx = 1; ac = 1; end
         else if (k == 1) begin nx = 2; ac = 2; end
      1: if (k == 1) begin nx = 2; ac = 2; end
         else if (k == 3 || k == 4) nx = 0;
      2: if (k == 2) begin nx = 1; ac = 3; end
         else if (k == 3 || k == 4) begin nx = 0; ac = 3; end
      default: ;
    endcase
  endfunction

  task automatic model_step();
    bit rdy, pop;
    int nx, ac, cd, a;
    rdy = (m_q.size() < 4);
    pop = (m_q.size() > 0) && vb_ready;
    m_acc = txn_valid && rdy;
    a = int'(txn_addr);
    ref_tbl(m_tag[a], int'(txn_kind), nx, ac);
    if (int'(txn_init) != m_tag[a]) cd = 1;
    else if (int'(txn_final) != nx) cd = 2;
    else if (int'(txn_act) != ac)   cd = 3;
    else cd = 0;
    if (pop) void'(m_q.pop_front());
    m_ev = m_acc && cd != 0;
    if (m_acc) begin
      m_code = cd; m_eaddr = a;
      if (cd == 0) begin
        if ((m_tag[a] == 0 && nx != 0) || (m_tag[a] == 1 && nx == 2) ||
            (m_tag[a] == 2 && nx == 0))
          m_q.push_back({txn_addr, 2'(nx)});
        m_tag[a] = nx;
      end
    end
    if (req_issue) begin
      m_armed = 1; m_cnt = 0; m_to = 0; m_waddr = int'(req_addr);
    end else if (m_armed && m_acc && txn_kind <= 3'd1 && a == m_waddr) begin
      m_armed = 0;
    end else if (m_armed) begin
      if (m_cnt == int'(wd_limit) - 1) begin m_to = 1; m_armed = 0; end
      else m_cnt++;
    end
  endtask

  task automatic compare();
    chk("txn_ready", "R8", int'(txn_ready), int'(m_q.size() < 4));
    chk("vb_valid", "R7", int'(vb_valid), int'(m_q.size() > 0));
    if (m_q.size() > 0) begin
      chk("vb_addr", "R8", int'(vb_addr), int'(m_q[0][5:2]));
      chk("vb_state", "R7", int'(vb_state), int'(m_q[0][1:0]));
    end
    chk("err_valid", tag, int'(err_valid), int'(m_ev));
    chk("err_code", tag, int'(err_code), m_code);
    chk("err_addr", "R10", int'(err_addr), m_eaddr);
    chk("wd_timeout", "R9", int'(wd_timeout), int'(m_to));
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    req_issue = 1'b0;
    compare();
  endtask

  task automatic send(int a, int k, int i, int f, int ac, int rel = -1);
    int w = 0;
    txn_valid = 1'b1; txn_addr = AW'(a); txn_kind = 3'(k);
    txn_init = 2'(i); txn_final = 2'(f); txn_act = 2'(ac);
    do begin
      if (w == rel) vb_ready = 1'b1;
      tick();
      w++;
    end while (!m_acc);
    txn_valid = 1'b0;
  endtask

  initial begin
    n_run = 0; n_fail = 0; tag = "R1";
    for (int i = 0; i < 16; i++) m_tag[i] = 0;
    m_ev = 0; m_code = 0; m_eaddr = 0; m_armed = 0; m_to = 0; m_cnt = 0; m_waddr = 0;
    rst_n = 1'b0; txn_valid = 1'b0; txn_addr = '0; txn_kind = '0; txn_init = '0;
    txn_final = '0; txn_act = '0; vb_ready = 1'b1; req_issue = 1'b0; req_addr = '0;
    wd_limit = CW'(6);
    repeat (3) @(negedge clk);
    compare();                                  // R1 reset state
    rst_n = 1'b1;
    tick();
    tag = "R5"; send(3, 0, 0, 1, 1); tick();    // I->S load, broadcast
    tag = "R7"; send(3, 1, 1, 2, 2); tick();    // S->M upgrade, broadcast
    tag = "R5"; send(3, 2, 2, 1, 3); tick();    // M->S snoop read, no broadcast
    tag = "R2"; send(5, 0, 1, 1, 1); tick();    // wrong initial state
    tag = "R2"; send(5, 0, 3, 1, 1); tick();    // initial 3 never stored
    tag = "R3"; send(5, 0, 0, 2, 1); tick();    // wrong final state
    tag = "R4"; send(5, 0, 0, 1, 0); tick();    // wrong action
    tag = "R4"; send(5, 0, 2, 2, 0); tick();    // init error wins
    tag = "R6"; send(5, 4, 0, 0, 0); tick();    // tag stayed I after errors
    tag = "R10"; send(5, 0, 0, 1, 1); tick();
    tag = "R7"; send(3, 4, 1, 0, 0); tick();    // S->I evict, no broadcast
    tag = "R7"; send(7, 1, 0, 2, 2); send(7, 4, 2, 0, 3); tick(); // I->M, M->I
    tag = "R5"; send(5, 6, 1, 1, 0); tick();    // reserved kind: no change
    tag = "R5"; send(5, 3, 1, 0, 0); send(7, 2, 0, 0, 0); tick();
    // R8: buffer fills with bus stalled, fifth transition waits
    tag = "R8"; vb_ready = 1'b0;
    for (int a = 8; a < 12; a++) send(a, 0, 0, 1, 1);
    repeat (3) tick();
    send(12, 1, 0, 2, 2, 4);
    repeat (6) tick();
    // R9: cleared by completion, then expiry and sticky flag
    tag = "R9";
    req_issue = 1'b1; req_addr = AW'(9); tick(); tick();
    send(9, 1, 1, 2, 2);
    repeat (10) tick();
    req_issue = 1'b1; req_addr = AW'(13); tick();
    send(14, 0, 0, 1, 1);                       // other line: no clear
    repeat (9) tick();
    req_issue = 1'b1; req_addr = AW'(13); tick(); // re-issue clears flag
    send(13, 0, 0, 1, 1);
    repeat (8) tick();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule